// File: doc/BRIEF.md
# E1 Frame Aligner

This block finds the 256-bit frame boundary in an E1 NRZ bit stream. The stream carries 32 timeslots of 8 bits per 125 µs frame. Timeslot 0 comes first, and the most significant bit of each timeslot comes first. Timeslot 0 holds the alignment word 0011011 in bits 2 to 8 on every other frame. The frames in between carry a 1 in bit 2.

After reset the block hunts bit by bit for a candidate alignment word. It then checks the next two frames at fixed 256-bit offsets before it declares alignment. While aligned it tracks the bit position, marks each frame start and watches the overhead for runs of errors. It falls back into the hunt automatically, or only when software asks, depending on configuration.

The receive clock is connected so that its sampling (falling) edge is the rising edge of `clk_i`. Downstream logic uses the position outputs, the frame pulse and the alignment flags to locate timeslots.

Top module: `e1_frame_aligner`

## Requirements
- R1: While aligned, `{slot_o, bit_o}` gives the frame position of the bit now on `rx_bit_i`. Position 0 is bit 1 of timeslot 0, and the position advances by one each clock, modulo 256. `frame_pulse_o` is high for exactly one clock, at position 0, once per frame.
- R2: Alignment is declared only after three frame checks at 256-bit spacing. Bits 2 to 8 of timeslot 0 must hold 0011011 in frame N, bit 2 must be 1 in frame N+1, and the 0011011 word must appear again in frame N+2. `in_sync_o` rises at the clock edge that samples bit 8 of timeslot 0 of frame N+2, and the position is 8 right after that edge. The hunt tests every bit offset.
- R3: If frame N+1 has bit 2 equal to 0 (for example because it holds an alignment word), or if frame N+2 lacks the alignment word, the block goes back to hunting and does not declare alignment.
- R4: While aligned, three consecutive alignment-word frames received with an error in bits 2 to 8 cause loss of alignment. A correct alignment word between errored ones restarts the run.
- R5: With `alt_loss_i` low, errors in bit 2 of the frames without the alignment word never cause loss of alignment.
- R6: With `alt_loss_i` high, three consecutive non-alignment frames whose bit 2 is 0 also cause loss of alignment.
- R7: With `auto_resync_en_i` low, meeting a loss criterion leaves the block aligned at its current position.
- R8: A low-to-high transition of `resync_req_i` forces the hunt at the next clock edge, whatever the current state. Holding the input high starts no further hunt; it must fall and rise again.
- R9: During and after reset the block is hunting: `in_sync_o` is 0, `los_o` is 1 and `frame_pulse_o` is 0. At all times `los_o` is the inverse of `in_sync_o`.
- R10: `data_o` follows `rx_bit_i`. When `force_ones_i` is high and the block is not aligned, `data_o` is 1 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the rising edge samples `rx_bit_i` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received NRZ serial data |
| resync_req_i | input | 1 | Manual hunt request; acts on its rising edge |
| auto_resync_en_i | input | 1 | 1: a loss criterion starts the hunt; 0: alignment is held |
| alt_loss_i | input | 1 | 1: errored bit 2 in non-alignment frames also counts toward loss |
| force_ones_i | input | 1 | 1: drive all ones on `data_o` while not aligned |
| frame_pulse_o | output | 1 | One-clock pulse at frame position 0 while aligned |
| slot_o | output | 5 | Timeslot index of the current bit |
| bit_o | output | 3 | Bit index within the timeslot, 0 being the MSB |
| in_sync_o | output | 1 | Frame alignment held |
| los_o | output | 1 | Hunting for alignment |
| data_o | output | 1 | Received data, conditioned by `force_ones_i` |

## Verification
The hardest behaviour to reach from the ports is a loss criterion acting on an already aligned stream. Examples are the three-run loss on bit 2 errors, the same run broken by one good frame, and a run that is met while automatic resync is off. Each of these needs a full three-frame acquisition first. After that the frames must keep the alternation the block expects, while single overhead bits are corrupted in chosen frames. The stimulus is a whole-frame generator that takes one timeslot 0 byte per frame and fills every other slot with ones, so no false alignment word can appear. It starts off-phase so that the bit-by-bit hunt is exercised. Frame sequences then drive the block through acquisition, failed confirmation, error runs, held alignment and edge-triggered resync, and the flags are checked at each frame end.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

   // Aligner control states
   typedef enum logic [1:0] {
      FA_HUNT      = 2'd0,   // sliding bit-by-bit search
      FA_CONF_ALT  = 2'd1,   // expect bit 2 = 1 one frame later
      FA_CONF_WORD = 2'd2,   // expect alignment word two frames later
      FA_LOCKED    = 2'd3    // aligned, monitoring overhead
   } fa_state_e;

   // Error-run monitor indices
   localparam int unsigned MON_WORD  = 0;   // alignment word errors
   localparam int unsigned MON_SPARE = 1;   // bit 2 errors in alternate frames
   localparam int unsigned MON_COUNT = 2;

endpackage

// File: rtl/e1fa_window.sv
// Sliding window over the last overhead-word bits, including the bit being sampled.
module e1fa_window #(
   parameter int unsigned WORD_BITS = 8,
   parameter logic [WORD_BITS-2:0] ALIGN_WORD = 7'b0011011
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bit_i,
   output logic word_hit_o,
   output logic spare_one_o
);
   localparam int unsigned CMP_BITS  = WORD_BITS - 1;
   localparam int unsigned HIST_BITS = CMP_BITS - 1;

   logic [HIST_BITS-1:0] hist_q;
   logic [CMP_BITS-1:0]  win;

   assign win = {hist_q, bit_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '1;
      else         hist_q <= win[HIST_BITS-1:0];
   end

   assign word_hit_o  = (win == ALIGN_WORD);
   assign spare_one_o = win[CMP_BITS-1];
endmodule

// File: rtl/e1fa_poscnt.sv
// Frame position counter with load.
module e1fa_poscnt #(
   parameter int unsigned FRAME_BITS = 256,
   parameter int unsigned POS_W = $clog2(FRAME_BITS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [POS_W-1:0] load_val_i,
   output logic [POS_W-1:0] pos_o
);
   logic [POS_W-1:0] pos_q, pos_inc;

   generate
      if ((1 << POS_W) == FRAME_BITS) begin : g_wrap
         assign pos_inc = pos_q + 1'b1;
      end else begin : g_cmp
         assign pos_inc = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pos_q <= '0;
      else if (load_i) pos_q <= load_val_i;
      else             pos_q <= pos_inc;
   end

   assign pos_o = pos_q;
endmodule

// File: rtl/e1fa_runmon.sv
// Consecutive-error run counter; trips on the error that completes a run.
module e1fa_runmon #(
   parameter int unsigned RUN = 3,
   parameter int unsigned CNT_W = $clog2(RUN + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic check_i,
   input  logic err_i,
   output logic trip_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (check_i) begin
         if (!err_i)                       cnt_q <= '0;
         else if (cnt_q != CNT_W'(RUN))    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign trip_o = check_i & err_i & ~clear_i & (cnt_q >= CNT_W'(RUN - 1));
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned LOSS_RUN  = 3,
   parameter logic [SLOT_BITS-2:0] ALIGN_WORD = 7'b0011011,
   localparam int unsigned BIT_W      = $clog2(SLOT_BITS),
   localparam int unsigned SLOT_W     = $clog2(SLOTS),
   localparam int unsigned POS_W      = SLOT_W + BIT_W,
   localparam int unsigned FRAME_BITS = SLOTS * SLOT_BITS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_bit_i,
   input  logic              resync_req_i,
   input  logic              auto_resync_en_i,
   input  logic              alt_loss_i,
   input  logic              force_ones_i,
   output logic              frame_pulse_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [BIT_W-1:0]  bit_o,
   output logic              in_sync_o,
   output logic              los_o,
   output logic              data_o
);
   import e1fa_pkg::*;

   // Elaboration-time parameter checks
   generate
      if (SLOT_BITS < 3 || (1 << BIT_W) != SLOT_BITS) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two of at least 4");
      end
      if (SLOTS < 3 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
         $error("SLOTS must be a power of two of at least 4");
      end
      if (LOSS_RUN < 1) begin : g_bad_run
         $error("LOSS_RUN must be at least 1");
      end
   endgenerate

   localparam logic [POS_W-1:0] POS_CHECK = POS_W'(SLOT_BITS - 1);
   localparam logic [POS_W-1:0] POS_AFTER = POS_W'(SLOT_BITS);

   fa_state_e        state_q, state_d;
   logic             expect_word_q, expect_word_d;
   logic             resync_q;
   logic             rise, locked, at_check, load, lose;
   logic             word_hit, spare_one;
   logic [POS_W-1:0] pos;

   logic [MON_COUNT-1:0] mon_check, mon_err, mon_clear, mon_trip;

   e1fa_window #(
      .WORD_BITS (SLOT_BITS),
      .ALIGN_WORD(ALIGN_WORD)
   ) i_window (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bit_i      (rx_bit_i),
      .word_hit_o (word_hit),
      .spare_one_o(spare_one)
   );

   e1fa_poscnt #(
      .FRAME_BITS(FRAME_BITS),
      .POS_W     (POS_W)
   ) i_poscnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .load_val_i(POS_AFTER),
      .pos_o     (pos)
   );

   assign rise     = resync_req_i & ~resync_q;
   assign locked   = (state_q == FA_LOCKED);
   assign at_check = (pos == POS_CHECK);

   // Monitor hookup: word errors always count, bit-2 errors only in the alternate criterion
   assign mon_check[MON_WORD]  = locked & at_check & expect_word_q;
   assign mon_err[MON_WORD]    = ~word_hit;
   assign mon_clear[MON_WORD]  = ~locked | rise;
   assign mon_check[MON_SPARE] = locked & at_check & ~expect_word_q;
   assign mon_err[MON_SPARE]   = ~spare_one;
   assign mon_clear[MON_SPARE] = ~locked | rise | ~alt_loss_i;

   generate
      for (genvar m = 0; m < MON_COUNT; m++) begin : g_mon
         e1fa_runmon #(
            .RUN(LOSS_RUN)
         ) i_runmon (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clear_i(mon_clear[m]),
            .check_i(mon_check[m]),
            .err_i  (mon_err[m]),
            .trip_o (mon_trip[m])
         );
      end
   endgenerate

   assign lose = |mon_trip;

   always_comb begin
      state_d       = state_q;
      expect_word_d = expect_word_q;
      load          = 1'b0;
      if (rise) begin
         state_d = FA_HUNT;
      end else begin
         case (state_q)
            FA_HUNT: begin
               if (word_hit) begin
                  state_d = FA_CONF_ALT;
                  load    = 1'b1;
               end
            end
            FA_CONF_ALT: begin
               if (at_check) state_d = spare_one ? FA_CONF_WORD : FA_HUNT;
            end
            FA_CONF_WORD: begin
               if (at_check) begin
                  if (word_hit) begin
                     state_d       = FA_LOCKED;
                     expect_word_d = 1'b0;
                  end else begin
                     state_d = FA_HUNT;
                  end
               end
            end
            FA_LOCKED: begin
               if (at_check) begin
                  expect_word_d = ~expect_word_q;
                  if (lose && auto_resync_en_i) state_d = FA_HUNT;
               end
            end
            default: state_d = FA_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q       <= FA_HUNT;
         expect_word_q <= 1'b0;
         resync_q      <= 1'b0;
      end else begin
         state_q       <= state_d;
         expect_word_q <= expect_word_d;
         resync_q      <= resync_req_i;
      end
   end

   assign slot_o        = pos[POS_W-1:BIT_W];
   assign bit_o         = pos[BIT_W-1:0];
   assign frame_pulse_o = locked & (pos == '0);
   assign in_sync_o     = locked;
   assign los_o         = ~locked;
   assign data_o        = rx_bit_i | (force_ones_i & ~locked);
endmodule

// File: rtl/e1fa_checker.sv
module e1fa_checker #(
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned BIT_W  = 3,
   parameter int unsigned POS_W  = SLOT_W + BIT_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              resync_req_i,
   input logic              auto_resync_en_i,
   input logic              frame_pulse_o,
   input logic [SLOT_W-1:0] slot_o,
   input logic [BIT_W-1:0]  bit_o,
   input logic              in_sync_o
);
   logic [POS_W-1:0] pos;
   assign pos = {slot_o, bit_o};

   a_r1_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_pulse_o |=> !frame_pulse_o);

   a_r1_pulse_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_pulse_o |=> (pos == POS_W'(1)));

   a_r1_pos_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_sync_o |=> (pos == POS_W'($past(pos) + 1'b1)));

   a_r2_entry_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(in_sync_o) |-> (pos == POS_W'(1 << BIT_W)));

   a_r7_hold_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_sync_o && !auto_resync_en_i && !$rose(resync_req_i)) |=> in_sync_o);

   a_r8_resync_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(resync_req_i) |=> !in_sync_o);
endmodule

bind e1_frame_aligner e1fa_checker #(
   .SLOT_W(SLOT_W),
   .BIT_W (BIT_W),
   .POS_W (POS_W)
) i_e1fa_checker (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .resync_req_i    (resync_req_i),
   .auto_resync_en_i(auto_resync_en_i),
   .frame_pulse_o   (frame_pulse_o),
   .slot_o          (slot_o),
   .bit_o           (bit_o),
   .in_sync_o       (in_sync_o)
);

// File: tb/test_e1_frame_aligner.sv
module test_e1_frame_aligner;
   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 256;
   localparam int WATCHDOG   = 100000;

   // Timeslot 0 bytes, MSB first
   localparam logic [7:0] TW = 8'h9B;  // alignment word 0011011 in bits 2..8
   localparam logic [7:0] TN = 8'hDF;  // non-alignment frame, bit 2 = 1
   localparam logic [7:0] TX = 8'h9A;  // alignment word with bit 8 in error
   localparam logic [7:0] TB = 8'h9F;  // non-alignment frame, bit 2 = 0

   // {timeslot 0 byte, expected in_sync at frame end}
   localparam int NV = 29;
   localparam logic [8:0] VEC [NV] = '{
      {TW,1'b0}, {TN,1'b0}, {TW,1'b1},             // R2 acquisition
      {TN,1'b1}, {TW,1'b1}, {TN,1'b1},
      {TX,1'b1}, {TN,1'b1}, {TX,1'b1}, {TN,1'b1},  // R4 two errors
      {TW,1'b1}, {TN,1'b1},                        // R4 run restarted
      {TX,1'b1}, {TN,1'b1}, {TX,1'b1}, {TN,1'b1},
      {TX,1'b0},                                   // R4 third consecutive error
      {TW,1'b0}, {TW,1'b0},                        // R3 frame N+1 carries the word
      {TN,1'b0}, {TW,1'b0}, {TN,1'b0}, {TW,1'b1},  // R2 reacquire
      {TB,1'b1}, {TW,1'b1}, {TB,1'b1}, {TW,1'b1},  // R5 bit 2 errors ignored
      {TB,1'b1}, {TW,1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b1;
   logic       resync = 1'b0;
   logic       auto_en = 1'b1;
   logic       alt_loss = 1'b0;
   logic       force_ones = 1'b0;
   logic       frame_pulse, in_sync, los, data;
   logic [4:0] slot;
   logic [2:0] bitpos;

   int  checks = 0;
   int  errors = 0;
   logic exp_lock = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   e1_frame_aligner i_e1_frame_aligner (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .rx_bit_i        (rx_bit),
      .resync_req_i    (resync),
      .auto_resync_en_i(auto_en),
      .alt_loss_i      (alt_loss),
      .force_ones_i    (force_ones),
      .frame_pulse_o   (frame_pulse),
      .slot_o          (slot),
      .bit_o           (bitpos),
      .in_sync_o       (in_sync),
      .los_o           (los),
      .data_o          (data)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      @(negedge clk);
      rx_bit = v;
      #1;
   endtask

   task automatic send_frame(input logic [7:0] ts0, input logic exp_after, input string tag);
      for (int b = 0; b < FRAME; b++) begin
         logic v;
         v = (b < 8) ? ts0[7-b] : 1'b1;
         drive_bit(v);
         if (b == 0)
            chk(frame_pulse == exp_lock, "R1 pulse at frame start", frame_pulse, exp_lock);
         if (b == 1 && exp_lock)
            chk(frame_pulse == 1'b0, "R1 pulse one clock wide", frame_pulse, 0);
         if ((b == 0 || b == 77) && exp_lock)
            chk({slot, bitpos} == 8'(b), "R1 position", {slot, bitpos}, b);
         if (b == 2) begin
            logic e;
            e = (force_ones && !exp_lock) ? 1'b1 : v;
            chk(data == e, "R10 data output", data, e);
         end
      end
      chk(in_sync == exp_after, tag, in_sync, exp_after);
      chk(los == !exp_after, "R9 los inverse of in_sync", los, !exp_after);
      exp_lock = exp_after;
   endtask

   // Raise the resync request and confirm the hunt one edge later (R8)
   task automatic rise_resync();
      resync = 1'b1;
      @(posedge clk);
      #1;
      chk(in_sync == 1'b0, "R8 hunt after rising edge", in_sync, 0);
      exp_lock = 1'b0;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // R9 reset state
      repeat (3) @(negedge clk);
      #1;
      chk(in_sync == 1'b0, "R9 reset in_sync", in_sync, 0);
      chk(los == 1'b1, "R9 reset los", los, 1);
      chk(frame_pulse == 1'b0, "R9 reset pulse", frame_pulse, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(los == 1'b1, "R9 hunting after reset", los, 1);

      // Off-phase lead-in so the hunt must slide
      for (int k = 0; k < 37; k++) drive_bit(1'b1);

      // Table walk: R2 R3 R4 R5
      for (int i = 0; i < NV; i++)
         send_frame(VEC[i][8:1], VEC[i][0], $sformatf("R2/R3/R4/R5 table row %0d in_sync", i));

      // R6: alternate criterion
      alt_loss = 1'b1;
      send_frame(TB, 1'b1, "R6 first bit 2 error");
      send_frame(TW, 1'b1, "R6 word frame");
      send_frame(TB, 1'b1, "R6 second bit 2 error");
      send_frame(TW, 1'b1, "R6 word frame");
      send_frame(TN, 1'b1, "R6 good frame restarts run");
      send_frame(TW, 1'b1, "R6 word frame");
      send_frame(TB, 1'b1, "R6 run error 1");
      send_frame(TW, 1'b1, "R6 word frame");
      send_frame(TB, 1'b1, "R6 run error 2");
      send_frame(TW, 1'b1, "R6 word frame");
      force_ones = 1'b1;                              // R10 aligned: pass-through
      send_frame(TB, 1'b0, "R6 third bit 2 error loses alignment");
      alt_loss = 1'b0;

      // R10 forced ones while hunting, then R2 reacquire
      send_frame(TW, 1'b0, "R2 candidate");
      send_frame(TN, 1'b0, "R2 alternate frame");
      send_frame(TW, 1'b1, "R2 aligned again");
      send_frame(TN, 1'b1, "R10 aligned data");
      force_ones = 1'b0;

      // R7: automatic resync disabled
      auto_en = 1'b0;
      send_frame(TX, 1'b1, "R7 error 1");
      send_frame(TN, 1'b1, "R7 held");
      send_frame(TX, 1'b1, "R7 error 2");
      send_frame(TN, 1'b1, "R7 held");
      send_frame(TX, 1'b1, "R7 third error keeps alignment");
      send_frame(TN, 1'b1, "R7 held after run");

      // R8: edge-triggered manual resync
      rise_resync();
      send_frame(TW, 1'b0, "R8 hunting, candidate");
      send_frame(TN, 1'b0, "R8 alternate frame");
      send_frame(TW, 1'b1, "R8 aligned with request held high");
      send_frame(TN, 1'b1, "R8 level has no effect");
      resync = 1'b0;
      send_frame(TW, 1'b1, "R8 falling edge has no effect");
      rise_resync();
      send_frame(TN, 1'b0, "R8 second request hunts");
      send_frame(TW, 1'b0, "R8 candidate");
      send_frame(TN, 1'b0, "R8 alternate frame");
      send_frame(TW, 1'b1, "R8 aligned");

      // R3: word missing in frame N+2
      resync = 1'b0;
      send_frame(TN, 1'b1, "R3 aligned before");
      rise_resync();
      send_frame(TW, 1'b0, "R3 candidate");
      send_frame(TN, 1'b0, "R3 alternate frame");
      send_frame(TX, 1'b0, "R3 missing word returns to hunt");
      send_frame(TN, 1'b0, "R3 hunting");
      send_frame(TW, 1'b0, "R3 candidate");
      send_frame(TN, 1'b0, "R3 alternate frame");
      send_frame(TW, 1'b1, "R3 aligned");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule